// File: doc/BRIEF.md
# Four-Stage Fixed Sinc Decimator (÷80)

This block takes a narrow signed sample stream at the modulator rate and returns one wide signed word for every 80 accepted input samples. It is the fixed front filter that sits after a delta-sigma modulator, ahead of a programmable low-rate filter. With a 4.9152 MHz master clock the output rate is 3840 or 3200 samples per second, depending on the modulator rate. The output rate follows the master clock directly. The response is linear phase.

The filter is not a single uniform-order CIC. It is a cascade of four integrator–comb sections. The first two sections are short and run at the high rate, and the highest-order section runs at the lowest rate. Counted at the input rate, the sections are:
- a third-order boxcar of 2 taps at spacing 1;
- a second-order boxcar of 2 taps at spacing 2;
- a third-order boxcar of 4 taps at spacing 4;
- a fifth-order boxcar of 5 taps at spacing 16.

The decimation factors are 2, 2, 4 and 5. Each section has its own wrapping integrators, sized so that the result is exact. Each section hands a one-cycle strobe to the next section. The block gives no output until its impulse response span has filled with real samples.

Top module: `sinc5_decimator`

## Requirements
- R1: Output number m (counting from reset, m = 0, 1, …) is y(m) = Σ h[k]·x[80m+79−k]. Here x[i] is the i-th accepted input, counted from 0, and x[i] = 0 for i < 0. The kernel h is the convolution of the four section kernels: box(2, spacing 1) convolved with itself 3 times, box(2, spacing 2) twice, box(4, spacing 4) three times and box(5, spacing 16) five times. This gives 364 taps.
- R2: y_valid pulses for exactly one cycle for each 80 accepted inputs, and never on two consecutive cycles.
- R3: Outputs m = 0 to 3 are suppressed. The first y_valid after reset follows the 400th accepted input, and none appears after only 399.
- R4: Once warmed up, a constant input of +1 gives y_out = 6,400,000, which is the DC gain 2³·2²·4³·5⁵.
- R5: Once warmed up, a constant input of −2 (the most negative 2-bit code, 2'b10) gives exactly −12,800,000.
- R6: Long random full-scale streams match R1 exactly, even though the internal integrators wrap.
- R7: Idle cycles (x_valid low) between input samples do not change any output value.
- R8: y_out stays stable in every cycle in which y_valid is low.
- R9: While rst is high, and in the cycle after it, y_valid is low and y_out is 0. After rst falls, all filter state and the warm-up count start again from empty.
- R10: y_valid rises on the fourth rising edge after the edge that accepts input 80m+79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| x_valid | input | 1 | Input sample strobe (one sample per high cycle) |
| x_in | input | IN_W (2) | Signed modulator sample |
| y_valid | output | 1 | One-cycle strobe per decimated output |
| y_out | output | OUT_W (25) | Signed decimated result, top OUT_W bits of the full-precision word |

## Verification
An isolated impulse shows the tap order and the decimation phase. A design that sampled the wrong phase in any section, or that misordered the factors, would give a shifted or misshapen kernel. Constant full-scale inputs of both signs reveal integrator widths that are too narrow or sign extension that is missing. Such faults give a wrong DC value, most visibly for −2. Long random streams with random idle gaps expose wraparound faults and strobe-gating errors: a design that advanced on idle cycles would drift away from the reference. A reset in mid-stream, followed by exactly 399 and then 400 inputs, exposes an off-by-one in the warm-up counter and state left over from before the reset.

// File: rtl/sinc5_dec_pkg.sv
package sinc5_dec_pkg;

  localparam int N_SEC = 4;
  localparam int SEC_ORD [N_SEC] = '{3, 2, 3, 5};
  localparam int SEC_DEC [N_SEC] = '{2, 2, 4, 5};

  function automatic int ceil_log2(input int v);
    int r;
    r = 0;
    while ((64'(1) << r) < 64'(v)) r++;
    return r;
  endfunction

  // bits gained by one section: ceil(log2(ratio^order))
  function automatic int sec_growth(input int k);
    int p;
    p = 1;
    for (int i = 0; i < SEC_ORD[k]; i++) p = p * SEC_DEC[k];
    return ceil_log2(p);
  endfunction

  // word width after the first n sections
  function automatic int width_after(input int in_w, input int n);
    int w;
    w = in_w;
    for (int k = 0; k < n; k++) w = w + sec_growth(k);
    return w;
  endfunction

  function automatic int total_dec();
    int d;
    d = 1;
    for (int k = 0; k < N_SEC; k++) d = d * SEC_DEC[k];
    return d;
  endfunction

  // impulse response span (taps - 1) at the input rate
  function automatic int resp_span();
    int s, stride;
    s = 0;
    stride = 1;
    for (int k = 0; k < N_SEC; k++) begin
      s = s + SEC_ORD[k] * (SEC_DEC[k] - 1) * stride;
      stride = stride * SEC_DEC[k];
    end
    return s;
  endfunction

  // outputs to drop until the response window holds only real samples
  function automatic int warm_outputs();
    int d, a;
    d = total_dec();
    a = resp_span() - (d - 1);
    if (a <= 0) return 0;
    return (a + d - 1) / d;
  endfunction

endpackage

// File: rtl/sinc_section.sv
module sinc_section #(
  parameter int ORDER = 3,
  parameter int RATIO = 2,
  parameter int IN_W  = 2,
  parameter int OUT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(RATIO - 1);

  logic signed [OUT_W-1:0] in_ext;
  logic signed [OUT_W-1:0] integ_q [ORDER];
  logic signed [OUT_W-1:0] integ_d [ORDER];
  logic signed [OUT_W-1:0] dly_q   [ORDER];
  logic signed [OUT_W-1:0] comb_c  [ORDER+1];
  logic [CNT_W-1:0]        phase;

  assign in_ext = {{(OUT_W-IN_W){in_data[IN_W-1]}}, in_data};

  // integrator chain evaluated in one cycle; wraps modulo 2^OUT_W
  always_comb begin
    integ_d[0] = integ_q[0] + in_ext;
    for (int k = 1; k < ORDER; k++) integ_d[k] = integ_q[k] + integ_d[k-1];
    comb_c[0] = integ_d[ORDER-1];
    for (int k = 0; k < ORDER; k++) comb_c[k+1] = comb_c[k] - dly_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORDER; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
      phase     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        for (int k = 0; k < ORDER; k++) integ_q[k] <= integ_d[k];
        if (phase == LAST_PH) begin
          phase <= '0;
          for (int k = 0; k < ORDER; k++) dly_q[k] <= comb_c[k];
          out_data  <= comb_c[ORDER];
          out_valid <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R2: a section strobe is never two cycles wide
  assert_sec_strobe_gap_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R10: each section adds exactly one cycle after the accepting strobe
  assert_sec_latency_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

endmodule

// File: rtl/sinc_out_stage.sv
module sinc_out_stage #(
  parameter int FULL_W = 25,
  parameter int OUT_W  = 25,
  parameter int WARM   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [FULL_W-1:0] in_data,
  output logic                     y_valid,
  output logic signed [OUT_W-1:0]  y_out
);

  localparam int WC_W = (WARM > 0) ? $clog2(WARM + 1) : 1;
  localparam logic [WC_W-1:0] WARM_L = WC_W'(WARM);

  logic [WC_W-1:0] warm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt <= '0;
      y_valid  <= 1'b0;
      y_out    <= '0;
    end else begin
      y_valid <= 1'b0;
      if (in_valid) begin
        if (warm_cnt == WARM_L) begin
          y_out   <= in_data[FULL_W-1 -: OUT_W];
          y_valid <= 1'b1;
        end else begin
          warm_cnt <= warm_cnt + 1'b1;
        end
      end
    end
  end

  // R8: result held between strobes
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_out));

  // R2: output strobe one cycle wide
  assert_out_single_R2: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

endmodule

// File: rtl/sinc5_decimator.sv
module sinc5_decimator
  import sinc5_dec_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int OUT_W = width_after(IN_W, N_SEC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    x_valid,
  input  logic signed [IN_W-1:0]  x_in,
  output logic                    y_valid,
  output logic signed [OUT_W-1:0] y_out
);

  localparam int FULL_W = width_after(IN_W, N_SEC);
  localparam int DEC    = total_dec();
  localparam int WARM   = warm_outputs();

  for (genvar k = 0; k < N_SEC; k++) begin : g_sec
    localparam int IW = width_after(IN_W, k);
    localparam int OW = width_after(IN_W, k + 1);
    logic                 s_iv;
    logic signed [IW-1:0] s_id;
    logic                 sv;
    logic signed [OW-1:0] sd;

    if (k == 0) begin : g_first
      assign s_iv = x_valid;
      assign s_id = x_in;
    end else begin : g_next
      assign s_iv = g_sec[k-1].sv;
      assign s_id = g_sec[k-1].sd;
    end

    sinc_section #(
      .ORDER(SEC_ORD[k]),
      .RATIO(SEC_DEC[k]),
      .IN_W (IW),
      .OUT_W(OW)
    ) u_sec (
      .clk      (clk),
      .rst      (rst),
      .in_valid (s_iv),
      .in_data  (s_id),
      .out_valid(sv),
      .out_data (sd)
    );
  end

  sinc_out_stage #(
    .FULL_W(FULL_W),
    .OUT_W (OUT_W),
    .WARM  (WARM)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .in_valid(g_sec[N_SEC-1].sv),
    .in_data (g_sec[N_SEC-1].sd),
    .y_valid (y_valid),
    .y_out   (y_out)
  );

  // checker: accepted inputs since reset, saturating at the warm-up boundary
  localparam int LIM  = DEC * (WARM + 1);
  localparam int XC_W = $clog2(LIM + 1);
  logic [XC_W-1:0] x_seen;

  always_ff @(posedge clk) begin
    if (rst) x_seen <= '0;
    else if (x_valid && x_seen != XC_W'(LIM)) x_seen <= x_seen + 1'b1;
  end

  // R3: no result before the response window is full
  assert_warmup_R3: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> x_seen == XC_W'(LIM));

  // R9: reset clears the output strobe
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> !y_valid);

endmodule

// File: tb/sinc5_decimator_test.sv
`timescale 1ns/1ps
module sinc5_decimator_test;

  localparam int IN_W = 2;
  localparam int OW   = 25;
  localparam int DEC  = 80;
  localparam int WARM = 4;
  localparam int NT   = 364;
  localparam int MAXN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_valid = 1'b0;
  logic signed [IN_W-1:0] x_in = '0;
  logic y_valid;
  logic signed [OW-1:0] y_out;

  sinc5_decimator uut (
    .clk(clk), .rst(rst), .x_valid(x_valid), .x_in(x_in),
    .y_valid(y_valid), .y_out(y_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint h [NT];
  int xs [MAXN];
  int xs_len;

  // monitor state
  int cyc = 0;
  int in_cnt = 0;
  int last_acc = 0;
  int n_got = 0;
  longint got [64];
  int lat [64];
  int hold_err = 0;
  logic signed [OW-1:0] last_y = '0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst && x_valid) begin
      in_cnt = in_cnt + 1;
      if (in_cnt % DEC == 0) last_acc = cyc;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (y_valid) begin
        if (n_got < 64) begin
          got[n_got] = longint'(y_out);
          lat[n_got] = cyc - last_acc;
        end
        n_got = n_got + 1;
        last_y = y_out;
      end else if (y_out !== last_y) begin
        hold_err = hold_err + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_out(input int m);
    longint acc = 0;
    for (int k = 0; k < NT; k++) begin
      int idx = DEC * m + DEC - 1 - k;
      if (idx >= 0 && idx < xs_len) acc += h[k] * longint'(xs[idx]);
    end
    return acc;
  endfunction

  task automatic build_kernel();
    int ord [4] = '{3, 2, 3, 5};
    int dcm [4] = '{2, 2, 4, 5};
    longint tmp [NT];
    int stride = 1;
    int len = 1;
    for (int i = 0; i < NT; i++) h[i] = 0;
    h[0] = 1;
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < ord[s]; r++) begin
        for (int i = 0; i < NT; i++) tmp[i] = 0;
        for (int i = 0; i < len; i++)
          for (int t = 0; t < dcm[s]; t++) tmp[i + t * stride] += h[i];
        len = len + (dcm[s] - 1) * stride;
        for (int i = 0; i < NT; i++) h[i] = tmp[i];
      end
      stride = stride * dcm[s];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x_valid = 1'b0;
    repeat (3) @(negedge clk);
    in_cnt = 0; n_got = 0; hold_err = 0; last_y = '0;
    rst = 1'b0;
  endtask

  // drive xs[0..n-1]; gap_pct = chance of idle cycles before each sample
  task automatic drive(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        @(negedge clk);
        x_valid = 1'b0;
      end
      @(negedge clk);
      x_valid = 1'b1;
      x_in = IN_W'(xs[i]);
    end
    @(negedge clk);
    x_valid = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    int exp_n = xs_len / DEC - WARM;
    if (exp_n < 0) exp_n = 0;
    check(n_got == exp_n, {tag, " R2 output count"}, n_got, exp_n);
    for (int i = 0; i < n_got && i < 64; i++) begin
      longint e = ref_out(i + WARM);
      check(got[i] == e, {tag, " R1 value"}, got[i], e);
      check(lat[i] == 4, {tag, " R10 latency"}, lat[i], 4);
    end
    check(hold_err == 0, {tag, " R8 hold"}, hold_err, 0);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(y_valid == 1'b0, "R9 reset y_valid", y_valid, 0);
    check(y_out == '0, "R9 reset y_out", y_out, 0);
    do_reset();
    @(negedge clk);
    check(y_valid == 1'b0 && y_out == '0, "R9 after reset", y_out, 0);
  endtask

  task automatic t_impulse();
    do_reset();
    xs_len = 800;
    for (int i = 0; i < xs_len; i++) xs[i] = (i == 200) ? 1 : 0;
    drive(xs_len, 0);
    compare_all("impulse");
  endtask

  task automatic t_dc(input int c, input longint exp, input string tag);
    do_reset();
    xs_len = 1200;
    for (int i = 0; i < xs_len; i++) xs[i] = c;
    drive(xs_len, 0);
    compare_all(tag);
    for (int i = 0; i < n_got && i < 64; i++)
      check(got[i] == exp, tag, got[i], exp);
  endtask

  task automatic t_random(input int gap, input string tag);
    do_reset();
    xs_len = 2400;
    for (int i = 0; i < xs_len; i++) xs[i] = ($urandom % 2) ? 1 : -2;
    for (int i = 0; i < xs_len; i += 7) xs[i] = int'($signed(IN_W'($urandom)));
    drive(xs_len, gap);
    compare_all(tag);
  endtask

  task automatic t_midreset();
    do_reset();
    xs_len = 500;
    for (int i = 0; i < xs_len; i++) xs[i] = 1;
    drive(xs_len, 0);
    do_reset();
    xs_len = 399;
    for (int i = 0; i < 400; i++) xs[i] = -1;
    drive(399, 0);
    check(n_got == 0, "R3 none after 399", n_got, 0);
    @(negedge clk);
    x_valid = 1'b1; x_in = -2'sd1;
    @(negedge clk);
    x_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(n_got == 1, "R3 first after 400", n_got, 1);
    if (n_got == 1)
      check(got[0] == -64'sd6400000, "R9 clean restart", got[0], -64'sd6400000);
  endtask

  initial begin
    build_kernel();
    t_reset_state();
    t_impulse();
    t_dc(1, 64'sd6400000, "R4 dc +1");
    t_dc(-2, -64'sd12800000, "R5 dc -2");
    t_random(0, "R6 random");
    t_random(30, "R7 gaps");
    t_midreset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule